// File: doc/BRIEF.md
# Shared Atomic Read-Modify-Write Memory

This block is a small word-addressed memory that several requesters share through one atomic read-modify-write port. A requester presents an opcode, a word address and one or two operands. The unit grants one request per cycle. In that cycle it reads the addressed word, computes the updated word and writes it back. One cycle later it returns the word's value from before the update, together with the index of the requester it served.

Each request finishes its read, modify and write within the cycle in which it is accepted. A request accepted in the next cycle, to any address, therefore sees the updated word. No update is lost, even when all requesters hit the same location back to back. Requesters that contend are served in rotating order. Callers may rely only on atomicity, not on any particular order. Typical uses are shared counters, bounded work-queue indices, lock words built on compare-and-swap, and running minimum or maximum values.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Every accepted operation returns, one cycle after acceptance, the value the addressed word held just before that operation.
- R2: Opcode 0000 adds operand A, 0001 subtracts operand A, 1000 ANDs, 1001 ORs and 1100 XORs operand A into the word. Add and subtract are modulo 2^W.
- R3: Opcodes 0010 and 0011 store the unsigned minimum and maximum of the word and operand A. Opcodes 1010 and 1011 store the signed (two's complement) minimum and maximum. Opcode bit 3 selects signed comparison.
- R4: Opcode 0100 (bounded increment, limit in operand A) stores 0 when the old word is greater than or equal to the limit, and old+1 otherwise. The comparison is unsigned.
- R5: Opcode 0101 (bounded decrement, limit in operand A) stores the limit when the old word is 0 or greater than the limit, and old-1 otherwise. The comparison is unsigned.
- R6: Opcode 0110 stores operand A unconditionally. Opcode 0111 (compare-and-swap) stores operand B only when the old word equals operand A and otherwise leaves the word unchanged. Both return the old word.
- R7: Opcodes 1101, 1110 and 1111 leave the word unchanged and still return the old word.
- R8: A request accepted in the cycle right after another request to the same address sees that request's result, so back-to-back and contending updates are never lost.
- R9: At most one requester sees req_ready high in a cycle, and only while its req_valid is high. Grants rotate round-robin, starting after the last served requester, so a requester that holds req_valid is served within N cycles.
- R10: rsp_valid is high exactly in the cycle after an acceptance, and rsp_id carries the index of the requester that was served.
- R11: A synchronous active-low reset clears every word to 0 and drops rsp_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N | Per-requester request valid |
| req_ready | output | N | Per-requester grant; a request is accepted when valid and ready are both high |
| req_op | input | N*4 | Per-requester opcode, requester i in bits [4i+3:4i] |
| req_addr | input | N*AW | Per-requester word address |
| req_opa | input | N*W | Per-requester operand A (operand, limit or compare value) |
| req_opb | input | N*W | Per-requester operand B (swap value for compare-and-swap) |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | IDW | Index of the requester that was served |
| rsp_old | output | W | Word value before the operation |

## Verification
Some properties are checked by assertions on every cycle: the grant is one-hot and only goes to a requester that asks, every acceptance produces a response in the next cycle with the served index, the addressed word holds the computed result after the accepting edge, and no requester waits N cycles while it holds its request. Other behaviour only the bench's scenarios can show. This covers the value each opcode stores for boundary operands (signed versus unsigned extremes, the increment and decrement limits, compare hits and misses, undefined opcodes). It also covers the old-value sequence when three requesters increment one counter at the same time, and the alternating grant order under sustained contention.

// File: rtl/atom_pkg.sv
// Package: opcode encoding shared by the atomic unit and its bench.
// Assumes a 4-bit opcode; bit 3 selects signed comparison for min/max.
package atom_pkg;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'b0000,
        OP_SUB  = 4'b0001,
        OP_MINU = 4'b0010,
        OP_MAXU = 4'b0011,
        OP_INC  = 4'b0100,
        OP_DEC  = 4'b0101,
        OP_XCHG = 4'b0110,
        OP_CAS  = 4'b0111,
        OP_AND  = 4'b1000,
        OP_OR   = 4'b1001,
        OP_MINS = 4'b1010,
        OP_MAXS = 4'b1011,
        OP_XOR  = 4'b1100
    } atom_op_e;
endpackage

// File: rtl/atom_rr_arbiter.sv
// Module: round-robin arbiter. It grants one requester per cycle, and the
// search starts just after the last one granted. It assumes that a grant is
// always taken, because the parent accepts every granted request in the same
// cycle. It requires N >= 2.
module atom_rr_arbiter #(
    parameter int N   = 4,
    localparam int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   valid,
    output logic [N-1:0]   grant,
    output logic [IDW-1:0] grant_idx,
    output logic           grant_any
);
    logic [IDW-1:0] last_q;

    // Pick the first valid requester after last_q, in rotating order.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(last_q) + 1 + k;
            if (j >= N) j = j - N;
            if (!grant_any && valid[j]) begin
                grant_any    = 1'b1;
                grant[j]     = 1'b1;
                grant_idx    = IDW'(j);
            end
        end
    end

    // Remember the last served requester so that priority rotates.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= IDW'(N-1);
        else if (grant_any) last_q <= grant_idx;
    end

    // R9: never more than one grant, and only to a requester that asks.
    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~valid) == '0));
endmodule

// File: rtl/atom_alu.sv
// Module: combinational modify stage. From the old word, the opcode and two
// operands it computes the word to write back. It assumes that undefined
// opcodes must leave the word unchanged.
module atom_alu
    import atom_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   old_val,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [W-1:0]   new_val
);
    logic signed_cmp;
    logic less;

    // Compare for min/max; opcode bit 3 chooses a signed or unsigned view.
    always_comb begin
        signed_cmp = op[3];
        less = signed_cmp ? ($signed(old_val) < $signed(opa)) : (old_val < opa);
    end

    // Work out the updated word for each opcode.
    always_comb begin
        case (op)
            OP_ADD:  new_val = old_val + opa;
            OP_SUB:  new_val = old_val - opa;
            OP_MINU,
            OP_MINS: new_val = less ? old_val : opa;
            OP_MAXU,
            OP_MAXS: new_val = less ? opa : old_val;
            OP_INC:  new_val = (old_val >= opa) ? '0 : old_val + 1'b1;
            OP_DEC:  new_val = (old_val == '0 || old_val > opa) ? opa : old_val - 1'b1;
            OP_XCHG: new_val = opa;
            OP_CAS:  new_val = (old_val == opa) ? opb : old_val;
            OP_AND:  new_val = old_val & opa;
            OP_OR:   new_val = old_val | opa;
            OP_XOR:  new_val = old_val ^ opa;
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
// Module: shared word memory with one atomic read-modify-write port. Each
// cycle it accepts one granted request. It reads the word, modifies it and
// writes it back at the same edge, and it reports the old word one cycle
// later. It assumes that requesters hold their fields steady while
// req_valid is high.
module atomic_rmw_unit
    import atom_pkg::*;
#(
    parameter int N     = 4,
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int IDW  = $clog2(N),
    localparam int CW   = $clog2(N+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_valid,
    output logic [N-1:0]     req_ready,
    input  logic [N*OPW-1:0] req_op,
    input  logic [N*AW-1:0]  req_addr,
    input  logic [N*W-1:0]   req_opa,
    input  logic [N*W-1:0]   req_opb,
    output logic             rsp_valid,
    output logic [IDW-1:0]   rsp_id,
    output logic [W-1:0]     rsp_old
);
    logic [W-1:0]   mem [DEPTH];
    logic [IDW-1:0] sel;
    logic           acc;
    logic [OPW-1:0] s_op;
    logic [AW-1:0]  s_addr;
    logic [W-1:0]   s_opa, s_opb, s_old, s_new;

    atom_rr_arbiter #(.N(N)) u_arb (
        .clk(clk), .rst_n(rst_n), .valid(req_valid),
        .grant(req_ready), .grant_idx(sel), .grant_any(acc)
    );

    // Steer the granted requester's fields to the shared port.
    always_comb begin
        s_op   = req_op[sel*OPW +: OPW];
        s_addr = req_addr[sel*AW +: AW];
        s_opa  = req_opa[sel*W +: W];
        s_opb  = req_opb[sel*W +: W];
        s_old  = mem[s_addr];
    end

    atom_alu #(.W(W)) u_alu (
        .op(s_op), .old_val(s_old), .opa(s_opa), .opb(s_opb), .new_val(s_new)
    );

    // Storage: cleared on reset, written with the result on each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (acc) begin
            mem[s_addr] <= s_new;
        end
    end

    // Response register: old word and served index, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_old   <= '0;
        end else begin
            rsp_valid <= acc;
            if (acc) begin
                rsp_id  <= sel;
                rsp_old <= s_old;
            end
        end
    end

    // R10: each acceptance gives a response next cycle that names the requester.
    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid && rsp_id == $past(sel));

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    // R8: after the accepting edge the word holds the modify stage's result.
    assert_update_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> mem[$past(s_addr)] == $past(s_new));

    // R9: a requester that holds its request is never left waiting N cycles.
    for (genvar g = 0; g < N; g++) begin : g_wait
        logic [CW-1:0] wait_q;
        always_ff @(posedge clk) begin
            if (!rst_n || !req_valid[g] || req_ready[g]) wait_q <= '0;
            else                                        wait_q <= wait_q + 1'b1;
        end
        assert_no_starve_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q < CW'(N));
    end
endmodule

// File: tb/atomic_rmw_unit_bench.sv
// Bench: sweeps every opcode over boundary operands on a 3-requester,
// 8-bit, 4-word configuration, then drives contention scenarios.
module atomic_rmw_unit_bench;
    import atom_pkg::*;
    localparam int N = 3, W = 8, D = 4, AW = 2, IDW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] req_valid = '0, req_ready;
    logic [N*4-1:0]  req_op   = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*W-1:0]  req_opa  = '0, req_opb = '0;
    logic rsp_valid;
    logic [IDW-1:0] rsp_id;
    logic [W-1:0] rsp_old;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    atomic_rmw_unit #(.N(N), .W(W), .DEPTH(D)) u_atomic_rmw_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_old(rsp_old)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected stored word, derived from the requirement text.
    function automatic logic [W-1:0] expect_new(logic [3:0] op, logic [W-1:0] o,
                                                logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            4'b0000: return o + a;
            4'b0001: return o - a;
            4'b0010: return (o < a) ? o : a;
            4'b0011: return (o > a) ? o : a;
            4'b1010: return ($signed(o) < $signed(a)) ? o : a;
            4'b1011: return ($signed(o) > $signed(a)) ? o : a;
            4'b0100: return (o >= a) ? 8'd0 : o + 8'd1;
            4'b0101: return (o == 0 || o > a) ? a : o - 8'd1;
            4'b0110: return a;
            4'b0111: return (o == a) ? b : o;
            4'b1000: return o & a;
            4'b1001: return o | a;
            4'b1100: return o ^ a;
            default: return o;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'b0000, 4'b0001, 4'b1000, 4'b1001, 4'b1100: return "R2";
            4'b0010, 4'b0011, 4'b1010, 4'b1011: return "R3";
            4'b0100: return "R4";
            4'b0101: return "R5";
            4'b0110, 4'b0111: return "R6";
            default: return "R7";
        endcase
    endfunction

    // One request from requester r; returns the response seen one cycle later.
    task automatic do_op(int r, logic [3:0] op, int addr, logic [W-1:0] a,
                         logic [W-1:0] b, output logic [W-1:0] old);
        @(negedge clk);
        req_valid = '0;
        req_valid[r] = 1'b1;
        req_op[r*4 +: 4] = op;
        req_addr[r*AW +: AW] = AW'(addr);
        req_opa[r*W +: W] = a;
        req_opb[r*W +: W] = b;
        @(negedge clk);
        req_valid = '0;
        chk("R10 rsp_valid", int'(rsp_valid), 1);
        chk("R10 rsp_id", int'(rsp_id), r);
        old = rsp_old;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] vals [8] = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h55};
        logic [W-1:0] got;
        logic [W-1:0] seen [3];
        int ids [3];
        int n_seen;
        int combo = 0;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 rsp_valid after reset", int'(rsp_valid), 0);
        for (int a = 0; a < D; a++) begin
            do_op(a % N, 4'b1001, a, 8'h00, 8'h00, got);
            chk("R11 word cleared", int'(got), 0);
        end

        // Sweep: all 16 opcodes, boundary old values and operands.
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [W-1:0] o, a, b, e;
                    int r, ad;
                    o = vals[i]; a = vals[j]; b = vals[j] ^ 8'h3C;
                    r = combo % N; ad = combo % D; combo++;
                    do_op(r, 4'b0110, ad, o, 8'h00, got);
                    do_op((r + 1) % N, 4'(op), ad, a, b, got);
                    chk("R1 old value returned", int'(got), int'(o));
                    e = expect_new(4'(op), o, a, b);
                    do_op((r + 2) % N, 4'b1001, ad, 8'h00, 8'h00, got);
                    chk(req_of(4'(op)), int'(got), int'(e));
                end
            end
        end

        // R8: three requesters increment one counter at once; none is lost.
        do_op(0, 4'b0110, 1, 8'd10, 8'd0, got);
        @(negedge clk);
        for (int r = 0; r < N; r++) begin
            req_op[r*4 +: 4] = 4'b0100;
            req_addr[r*AW +: AW] = 2'd1;
            req_opa[r*W +: W] = 8'hFF;
        end
        n_seen = 0;
        begin
            logic [N-1:0] pending;
            pending = '1;
            for (int cyc = 0; cyc < 6; cyc++) begin
                if (rsp_valid && n_seen < 3) begin
                    seen[n_seen] = rsp_old; ids[n_seen] = int'(rsp_id); n_seen++;
                end
                req_valid = pending;
                #1;
                chk("R9 single grant", $countones(req_ready), (pending != 0) ? 1 : 0);
                @(posedge clk);
                pending = pending & ~req_ready;
                @(negedge clk);
            end
            req_valid = '0;
        end
        chk("R8 responses under contention", n_seen, 3);
        for (int k = 0; k < 3; k++) chk("R8 serial old values", int'(seen[k]), 10 + k);
        chk("R9 distinct requesters", int'(ids[0] != ids[1] && ids[1] != ids[2] && ids[0] != ids[2]), 1);
        do_op(0, 4'b1001, 1, 8'h00, 8'h00, got);
        chk("R8 counter final", int'(got), 13);

        // R9: requesters 0 and 1 hold valid; grants must alternate.
        @(negedge clk);
        for (int r = 0; r < 2; r++) begin
            req_op[r*4 +: 4] = 4'b0000;
            req_addr[r*AW +: AW] = 2'd2;
            req_opa[r*W +: W] = 8'd1;
        end
        req_valid = 3'b011;
        begin
            int prev;
            prev = -1;
            for (int cyc = 0; cyc < 6; cyc++) begin
                int cur;
                #1;
                cur = req_ready[0] ? 0 : (req_ready[1] ? 1 : 2);
                if (prev >= 0) chk("R9 round-robin alternation", cur, 1 - prev);
                prev = cur;
                @(negedge clk);
            end
        end
        req_valid = '0;

        // R11: reset in mid-use clears the words again.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 rsp_valid low", int'(rsp_valid), 0);
        do_op(2, 4'b1001, 1, 8'h00, 8'h00, got);
        chk("R11 cleared after reset", int'(got), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule